// File: doc/BRIEF.md
# Multi-DAC Serial Write Controller

This block is a host-side serial master. It writes 16-bit words to a group of voltage-output DACs that share one serial clock line and one data line. Each DAC has its own active-low chip select. A request is one address, one data word and one update-mode flag, and it is offered on a valid/ready port. The controller decodes the address so that only the chosen chip select goes low. It then shifts the word out most significant bit first and releases the select. Before it takes the next request it waits out a minimum high time on the selects.

The update-mode flag chooses how the converter output is updated. In immediate mode the shared load strobe is held low for the whole transaction, so the chip-select rising edge updates the DAC. In deferred mode the strobe stays high while the word is shifted. After the select has been high for a set number of cycles, the strobe is pulsed low. Several DACs can be loaded this way and then updated together. Parameters set the serial clock half-period, the select-to-strobe setup, the strobe width and the inter-frame gap, all in system clock cycles. The serial clock toggles only while a select is low. Addresses beyond the attached DAC count run a silent transaction.

Back-pressure rule: `req_ready` is high only while the controller is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. After that, `req_ready` stays low until the whole transaction and its gap are over. A host may hold `req_valid` high with the next request during that time. The next request is neither sampled nor taken until `req_ready` rises again.

Top module: `dac_wr_ctrl`

## Requirements
- R1: Each transaction to an attached DAC carries exactly the 16-bit request word, most significant bit first. One bit is presented for each rising edge of `sclk`, and the word read off the rising edges equals the request data.
- R2: `din` changes only while `sclk` is low: once when the select falls, and then on each falling edge of `sclk`. It is therefore stable at every rising edge.
- R3: With a chip select low, `sclk` rests low for HALF_CYC cycles before the first rise and after the last fall. Each high phase and each low phase lasts exactly HALF_CYC system clock cycles, and there are exactly 16 rising edges.
- R4: At most one bit of `cs_n` is ever low. Address a drives bit a of `cs_n` low from the cycle after acceptance for exactly 33*HALF_CYC cycles.
- R5: `sclk` is high only while some `cs_n` bit is low, and it idles low.
- R6: A request whose address is at least N_DAC is accepted and keeps `req_ready` low for as long as an attached-DAC request of the same mode. During it every `cs_n` bit stays high and `sclk` stays low.
- R7: `req_ready` is high only when idle. After acceptance it is low for exactly 33*HALF_CYC+GAP_CYC cycles in immediate mode (`req_defer`=0) and 33*HALF_CYC+SETUP_CYC+STROBE_CYC+GAP_CYC cycles in deferred mode (`req_defer`=1). A request held valid meanwhile is not taken early.
- R8: In immediate mode `ldac_n` is low from the cycle after acceptance until `req_ready` returns high.
- R9: In deferred mode `ldac_n` stays high through the shift and for SETUP_CYC cycles after `cs_n` returns high. It is then low for STROBE_CYC cycles and high again.
- R10: After reset, and whenever idle, all `cs_n` bits are high, `sclk` is low, `ldac_n` is high and `req_ready` is high.
- R11: Between two transactions all `cs_n` bits stay high for at least GAP_CYC cycles, even when requests arrive back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Target DAC index |
| req_data | input | DATA_W | Word to write |
| req_defer | input | 1 | 1 = deferred update with load strobe, 0 = immediate update |
| sclk | output | 1 | Serial clock, idles low |
| din | output | 1 | Serial data, MSB first |
| cs_n | output | N_DAC | Active-low chip selects, one per DAC |
| ldac_n | output | 1 | Shared active-low load strobe |

## Verification
A phase counter that is off by one changes the length of a serial clock phase or of the gap. It shows up in the first transaction as a wrong `sclk` phase width, a select held low too long or too short, or a `req_ready` edge in the wrong cycle. A bit counter or shift register that slips yields a word with more or fewer than 16 rising edges, or with bits moved. The scoreboard sees this when the select is released at the end of that frame. A wrong decode or a stale update-mode flag moves the select onto the wrong line or places the load strobe wrongly. Both are visible from the first cycle of the affected transaction.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HI,
    ST_LO,
    ST_TAIL,
    ST_SETUP,
    ST_STROBE,
    ST_GAP
  } wr_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/dac_cs_decode.sv
module dac_cs_decode #(
  parameter int N_DAC  = 4,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_DAC-1:0]  sel_n,
  output logic              hit
);
  for (genvar i = 0; i < N_DAC; i++) begin : g_sel
    assign sel_n[i] = (addr != ADDR_W'(i));
  end
  assign hit = ~&sel_n;
endmodule

// File: rtl/dac_bit_shift.sv
module dac_bit_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] word,
  output logic              msb
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= word;
    else if (shift) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign msb = sh_q[DATA_W-1];
endmodule

// File: rtl/dac_phase_cnt.sv
module dac_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl
  import dac_wr_pkg::*;
#(
  parameter int N_DAC      = 4,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int HALF_CYC   = 5,
  parameter int GAP_CYC    = 8,
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_defer,
  output logic              sclk,
  output logic              din,
  output logic [N_DAC-1:0]  cs_n,
  output logic              ldac_n
);
  localparam int MAX_CYC = max4(HALF_CYC, GAP_CYC, SETUP_CYC, STROBE_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(DATA_W);

  wr_state_t         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, dec_addr;
  logic              def_q, def_d;
  logic [BIT_W-1:0]  bit_q;
  logic              zero, accept, load, shift, hit, in_frame;
  logic [CNT_W-1:0]  load_val;
  logic [N_DAC-1:0]  sel_n;
  logic              sclk_q, ldac_q;
  logic [N_DAC-1:0]  cs_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_LEAD;
      ST_LEAD:   if (zero) state_d = ST_HI;
      ST_HI:     if (zero) state_d = (bit_q == BIT_W'(DATA_W - 1)) ? ST_TAIL : ST_LO;
      ST_LO:     if (zero) state_d = ST_HI;
      ST_TAIL:   if (zero) state_d = def_q ? ST_SETUP : ST_GAP;
      ST_SETUP:  if (zero) state_d = ST_STROBE;
      ST_STROBE: if (zero) state_d = ST_GAP;
      ST_GAP:    if (zero) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_SETUP:  load_val = CNT_W'(SETUP_CYC - 1);
      ST_STROBE: load_val = CNT_W'(STROBE_CYC - 1);
      ST_GAP:    load_val = CNT_W'(GAP_CYC - 1);
      ST_IDLE:   load_val = '0;
      default:   load_val = CNT_W'(HALF_CYC - 1);
    endcase
  end

  assign load     = (state_d != state_q);
  assign shift    = (state_q == ST_HI) && (state_d == ST_LO);
  assign dec_addr = accept ? req_addr : addr_q;
  assign def_d    = accept ? req_defer : def_q;
  assign in_frame = (state_d == ST_LEAD) || (state_d == ST_HI) ||
                    (state_d == ST_LO) || (state_d == ST_TAIL);

  dac_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(zero)
  );

  dac_bit_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(shift),
    .word(req_data), .msb(din)
  );

  dac_cs_decode #(.N_DAC(N_DAC), .ADDR_W(ADDR_W)) u_dec (
    .addr(dec_addr), .sel_n(sel_n), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      def_q   <= 1'b0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= '1;
      ldac_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr;
        def_q  <= req_defer;
        bit_q  <= '0;
      end else if (state_q == ST_HI && zero) begin
        bit_q <= bit_q + 1'b1;
      end
      sclk_q <= (state_d == ST_HI) && hit;
      cs_q   <= in_frame ? sel_n : '1;
      if (state_d == ST_STROBE)
        ldac_q <= 1'b0;
      else if (state_d != ST_IDLE && state_d != ST_SETUP && !def_d)
        ldac_q <= 1'b0;
      else
        ldac_q <= 1'b1;
    end
  end

  assign sclk   = sclk_q;
  assign cs_n   = cs_q;
  assign ldac_n = ldac_q;

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r5_sclk_framed: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !(&cs_n));
  a_r2_din_steady: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(din));
  a_r9_strobe_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ldac_n) && def_q) |-> (&cs_n));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&cs_n) && !sclk && ldac_n));
endmodule

// File: tb/sim_dac_wr_ctrl.sv
module sim_dac_wr_ctrl;
  localparam int N   = 4;
  localparam int AW  = 3;
  localparam int H   = 5;
  localparam int G   = 8;
  localparam int S   = 4;
  localparam int L   = 8;
  localparam int FR  = 33 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic req_defer = 1'b0;
  logic sclk, din, ldac_n;
  logic [N-1:0] cs_n;

  always #2 clk = ~clk;

  dac_wr_ctrl #(.N_DAC(N), .ADDR_W(AW), .DATA_W(16), .HALF_CYC(H),
                .GAP_CYC(G), .SETUP_CYC(S), .STROBE_CYC(L)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_defer(req_defer),
    .sclk(sclk), .din(din), .cs_n(cs_n), .ldac_n(ldac_n)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  typedef struct { logic [AW-1:0] a; logic [15:0] d; } item_t;
  item_t sb[$];

  // driver: called just after a rising edge, returns just after the accepting edge
  task automatic send(input logic [AW-1:0] a, input logic [15:0] d, input logic f);
    item_t it;
    #1;
    req_valid = 1'b1; req_addr = a; req_data = d; req_defer = f;
    if (a < N) begin it.a = a; it.d = d; sb.push_back(it); end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // per-transaction timing checker: R4 R6 R7 R8 R9 R11
  logic act = 1'b0;
  int k, tlen;
  logic [AW-1:0] c_a;
  logic c_f;
  int cs_err, ld_err, sc_err, rdy_err, idle_err;
  logic [N-1:0] cs_bad, cs_exp;
  logic ld_bad, ld_exp_b;
  logic [N-1:0] exp_cs;
  logic exp_ld, exp_rdy;
  initial idle_err = 0;

  always @(negedge clk) if (rst_n) begin
    if (act) begin
      k++;
      exp_cs  = (k <= FR && c_a < N) ? ~(N'(1) << c_a) : '1;
      exp_rdy = (k > tlen);
      if (k > tlen)      exp_ld = 1'b1;
      else if (!c_f)     exp_ld = 1'b0;
      else               exp_ld = !(k > FR + S && k <= FR + S + L);
      if (cs_n !== exp_cs) begin if (cs_err == 0) begin cs_bad = cs_n; cs_exp = exp_cs; end cs_err++; end
      if (ldac_n !== exp_ld) begin if (ld_err == 0) begin ld_bad = ldac_n; ld_exp_b = exp_ld; end ld_err++; end
      if (req_ready !== exp_rdy) rdy_err++;
      if (c_a >= N && sclk !== 1'b0) sc_err++;
      if (k == tlen + 1) begin
        if (c_a < N) check(cs_err == 0, "R4 R11 select pattern", cs_bad, cs_exp);
        else begin
          check(cs_err == 0, "R6 selects quiet", cs_bad, cs_exp);
          check(sc_err == 0, "R6 sclk quiet", sc_err, 0);
        end
        check(ld_err == 0, c_f ? "R9 deferred strobe" : "R8 immediate strobe", ld_bad, ld_exp_b);
        check(rdy_err == 0, "R7 ready window", rdy_err, 0);
        act = 1'b0;
      end
    end
    if (!act) begin
      if (cs_n !== '1 || sclk !== 1'b0 || ldac_n !== 1'b1 || req_ready !== 1'b1) idle_err++;
      if (req_valid && req_ready) begin
        act = 1'b1; k = 0; c_a = req_addr; c_f = req_defer;
        tlen = FR + G + (req_defer ? S + L : 0);
        cs_err = 0; ld_err = 0; sc_err = 0; rdy_err = 0;
      end
    end
  end

  // monitor / scoreboard: R1 R2 R3 R4 R5 R11
  logic prev_in = 1'b0, prev_sclk = 1'b0, prev_din = 1'b0;
  logic [15:0] word;
  int nb, run, ph_err, din_err, r5_err, hi_run;
  logic [N-1:0] low_mask;
  bit seen = 0;
  initial begin r5_err = 0; hi_run = 0; end

  always @(negedge clk) if (rst_n) begin
    logic in_f;
    item_t it;
    in_f = ~&cs_n;
    if (in_f && !prev_in) begin
      if (seen) check(hi_run >= G, "R11 select gap", hi_run, G);
      seen = 1; word = '0; nb = 0; run = 1; ph_err = 0; din_err = 0; low_mask = cs_n;
    end else if (in_f) begin
      if (cs_n !== low_mask) ph_err++;
      if (sclk !== prev_sclk) begin
        if (run != H) ph_err++;
        run = 1;
        if (sclk) begin
          if (din !== prev_din) din_err++;
          word = {word[14:0], din};
          nb++;
        end
      end else begin
        run++;
        if (sclk && din !== prev_din) din_err++;
      end
    end
    if (!in_f && prev_in) begin
      if (run != H) ph_err++;
      if (sb.size() == 0) check(1'b0, "R1 unexpected frame", word, 0);
      else begin
        it = sb.pop_front();
        check(word == it.d, "R1 shifted word", word, it.d);
        check(nb == 16, "R3 rising edge count", nb, 16);
        check(ph_err == 0, "R3 phase widths", ph_err, 0);
        check(din_err == 0, "R2 data stable at rise", din_err, 0);
        check(low_mask == ~(N'(1) << it.a), "R4 decoded select", low_mask, ~(N'(1) << it.a));
      end
    end
    if (!in_f && sclk) r5_err++;
    hi_run = in_f ? 0 : hi_run + 1;
    prev_in = in_f; prev_sclk = sclk; prev_din = din;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cs_n === '1, "R10 reset selects", cs_n, 4'hF);
    check(sclk === 1'b0 && ldac_n === 1'b1, "R10 reset sclk/strobe", {sclk, ldac_n}, 2'b01);
    check(req_ready === 1'b1, "R10 reset ready", req_ready, 1);
    @(posedge clk);
    send(3'd0, 16'hA5C3, 1'b0);
    send(3'd3, 16'hFFFF, 1'b0);
    send(3'd1, 16'h0000, 1'b1);
    send(3'd2, 16'h8001, 1'b1);
    send(3'd5, 16'h1234, 1'b0);
    send(3'd7, 16'h00FF, 1'b1);
    send(3'd3, 16'h7FFE, 1'b0);
    send(3'd0, 16'h8000, 1'b1);
    send(3'd2, 16'h5A5A, 1'b0);
    #1 req_valid = 1'b0;
    repeat (FR + S + L + G + 10) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R1 all words delivered", sb.size(), 0);
    check(r5_err == 0, "R5 sclk outside frame", r5_err, 0);
    check(idle_err == 0, "R10 idle outputs", idle_err, 0);
    summary();
    $finish;
  end
endmodule